// File: doc/BRIEF.md
# Stoppable Channel Phase Sequencer

This block generates the timing phases of a data channel. While idle it drives no phase. A start request makes it step through a fixed ring of named phases, A0 first and the last phase at the end, one phase per clock, and then return to idle. There are two start sources. One is the rising edge of the transfer-control strobe from the host controller. The other is a single-step pulse from the maintenance logic.

For diagnostics, the maintenance logic can pick one phase at which the sequence freezes. When the sequence reaches that phase, the phase output stays constant and a halted flag is raised, so the channel's state at that exact pulse can be captured. A later step pulse or strobe edge releases the freeze and the sequence continues from the following phase. The strobe has to be seen low before it can start another cycle, so a strobe held high starts at most one cycle.

Top module: `chan_step_clock`

## Requirements
- R1: A synchronous active-low reset puts the sequencer into idle: all phase outputs low, busy low and halted low. A strobe that is already high when reset is released does not start a cycle.
- R2: In idle, a strobe sample that is high after a low sample at the previous clock starts a cycle. Phase A0 (phase_o bit 0) is active in the clock after that sample.
- R3: In idle, a step pulse sampled high starts a cycle, with A0 active in the following clock.
- R4: Once started and not halted, the sequencer advances one phase per clock from A0 to the last phase (phase_o bit i is phase Ai) and then returns to idle. At most one phase bit is high at a time, and busy is high exactly while a phase is active.
- R5: A start request (step pulse or strobe edge) that arrives while a cycle is running and not halted is ignored and is not queued. The cycle length is unchanged and no new cycle follows.
- R6: A strobe that stays high through the end of a cycle does not start another one. The strobe must be sampled low before it can start again.
- R7: With stop_en high, when the sequencer enters the phase whose index equals stop_sel, halted rises in the same clock that this phase appears. The phase outputs then hold unchanged while halted is high.
- R8: While halted, a step pulse or a strobe rising edge moves the sequencer to the next phase, or to idle from the last phase, and clears halted. A falling strobe does not release the halt.
- R9: The sequencer halts at most once per cycle. Changing stop_sel while halted to the next phase does not cause a second halt.
- R10: With stop_en low, stop_sel has no effect and every started cycle runs to completion without halting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock, one phase per period |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_strobe_i | input | 1 | Transfer-control strobe; its rising edge starts or releases |
| step_pulse_i | input | 1 | Maintenance single-step pulse; starts or releases |
| stop_en_i | input | 1 | Enables the diagnostic halt |
| stop_sel_i | input | 3 | Index of the phase on which to halt |
| phase_o | output | 8 | One-hot phase outputs, bit i is phase Ai |
| busy_o | output | 1 | High while a cycle is in progress |
| halted_o | output | 1 | High while frozen on the selected phase |

## Verification
The bench sweeps every stop phase with the halt both enabled and disabled, covering both start sources and both release sources. Each phase is compared at every clock against an arithmetic model. A design that halted one phase late, or raised the flag a clock after the phase, would miss the first sampled halt. A strobe held high across the whole cycle catches a level-sensitive start, which would restart the cycle at once. A step pulse injected mid-cycle catches a queued or restarted request, which would stretch or repeat the sequence. Moving the stop select while halted catches a design that freezes a second time. A falling strobe during a halt catches a design that releases on any strobe change.

// File: rtl/chan_clk_pkg.sv
// Package: shared types and defaults for the channel phase sequencer.
// Assumes phases are numbered from zero in the order they are produced.
package chan_clk_pkg;

    localparam int unsigned DEF_PHASES = 8;

    // Sequencer states: idle, stepping through phases, frozen on a phase.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_HALT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/chan_clk_start_gate.sv
// Start gate: merges the maintenance step pulse with the rising edge of the
// transfer strobe into one start request. The strobe is armed only after
// it has been sampled low. Assumes both inputs are synchronous to clk.
module chan_clk_start_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_i,
    input  logic step_i,
    output logic go_o
);

    logic armed_q;
    logic strobe_edge;

    // Arm the strobe path while the strobe is seen low; reset disarms it.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= ~xfer_i;
    end

    // A start comes from an armed strobe or from a step pulse.
    always_comb begin
        strobe_edge = xfer_i & armed_q;
        go_o        = strobe_edge | step_i;
    end

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_edge |=> !strobe_edge);

endmodule

// File: rtl/chan_clk_stop_match.sv
// Stop matcher: decodes the selected stop phase into a mask and reports
// whether a candidate phase index is the one to freeze on. Assumes the
// select is stable while it is in use.
module chan_clk_stop_match #(
    parameter int NUM_PHASES = chan_clk_pkg::DEF_PHASES,
    localparam int SEL_W = $clog2(NUM_PHASES)
) (
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [SEL_W-1:0] cand_i,
    output logic             hit_o
);

    logic [NUM_PHASES-1:0] mask;

    // One mask bit per phase, set only for the enabled selected phase.
    for (genvar gi = 0; gi < NUM_PHASES; gi++) begin : g_mask
        assign mask[gi] = en_i && (sel_i == SEL_W'(gi));
    end

    // Look up the candidate in the mask.
    always_comb hit_o = mask[cand_i];

endmodule

// File: rtl/chan_clk_seq_core.sv
// Sequencer core: holds the state, the current phase index and a flag
// recording whether this cycle has already halted. It asks the stop
// matcher about the phase it is about to enter. Assumes go_i is a
// single-cycle request per event.
module chan_clk_seq_core
    import chan_clk_pkg::*;
#(
    parameter int NUM_PHASES = DEF_PHASES,
    localparam int SEL_W = $clog2(NUM_PHASES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             hit_i,
    input  logic             stop_en_i,
    output logic [SEL_W-1:0] cand_o,
    output logic [SEL_W-1:0] idx_o,
    output logic             active_o,
    output logic             halted_o
);

    localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NUM_PHASES - 1);

    seq_state_e       state_q, state_d;
    logic [SEL_W-1:0] idx_q, idx_d;
    logic             used_q, used_d;
    logic             at_last;

    // Candidate phase: A0 from idle, otherwise the phase after the current.
    always_comb begin
        at_last = (idx_q == LAST_IDX);
        cand_o  = (state_q == SEQ_IDLE) ? '0 : idx_q + 1'b1;
    end

    // Next-state logic for start, stepping, halting and release.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        used_d  = used_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (go_i) begin
                    idx_d   = '0;
                    used_d  = hit_i;
                    state_d = hit_i ? SEQ_HALT : SEQ_RUN;
                end
            end
            SEQ_RUN: begin
                if (at_last) begin
                    idx_d   = '0;
                    state_d = SEQ_IDLE;
                end else begin
                    idx_d = idx_q + 1'b1;
                    if (hit_i && !used_q) begin
                        used_d  = 1'b1;
                        state_d = SEQ_HALT;
                    end
                end
            end
            SEQ_HALT: begin
                if (go_i) begin
                    if (at_last) begin
                        idx_d   = '0;
                        state_d = SEQ_IDLE;
                    end else begin
                        idx_d   = idx_q + 1'b1;
                        state_d = SEQ_RUN;
                    end
                end
            end
            default: begin
                idx_d   = '0;
                state_d = SEQ_IDLE;
            end
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            used_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            used_q  <= used_d;
        end
    end

    // Drive the status outputs from the state.
    always_comb begin
        idx_o    = idx_q;
        active_o = (state_q != SEQ_IDLE);
        halted_o = (state_q == SEQ_HALT);
    end

    // R5
    run_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN && !at_last) |=> (active_o && idx_q == $past(idx_q) + 1'b1));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !go_i) |=> (halted_o && $stable(idx_q)));

    // R8
    halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && go_i) |=> !halted_o);

    // R9
    single_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN && used_q) |=> !halted_o);

    // R10
    no_halt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_en_i && !halted_o) |=> !halted_o);

endmodule

// File: rtl/chan_clk_phase_dec.sv
// Phase decoder: turns the phase index into one-hot phase outputs,
// all low while the sequencer is idle.
module chan_clk_phase_dec #(
    parameter int NUM_PHASES = chan_clk_pkg::DEF_PHASES,
    localparam int SEL_W = $clog2(NUM_PHASES)
) (
    input  logic                  active_i,
    input  logic [SEL_W-1:0]      idx_i,
    output logic [NUM_PHASES-1:0] phase_o
);

    // One output per phase, high when active and the index matches.
    for (genvar gi = 0; gi < NUM_PHASES; gi++) begin : g_dec
        assign phase_o[gi] = active_i && (idx_i == SEL_W'(gi));
    end

endmodule

// File: rtl/chan_step_clock.sv
// Top: stoppable channel phase sequencer. It starts on a strobe edge or a
// step pulse, walks A0..A(N-1) one per clock, and can freeze on a selected
// phase. Assumes all inputs are synchronous to clk.
module chan_step_clock #(
    parameter int NUM_PHASES = chan_clk_pkg::DEF_PHASES,
    localparam int SEL_W = $clog2(NUM_PHASES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xfer_strobe_i,
    input  logic                  step_pulse_i,
    input  logic                  stop_en_i,
    input  logic [SEL_W-1:0]      stop_sel_i,
    output logic [NUM_PHASES-1:0] phase_o,
    output logic                  busy_o,
    output logic                  halted_o
);

    logic             go;
    logic             hit;
    logic             active;
    logic [SEL_W-1:0] cand;
    logic [SEL_W-1:0] idx;

    chan_clk_start_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .xfer_i (xfer_strobe_i),
        .step_i (step_pulse_i),
        .go_o   (go)
    );

    chan_clk_stop_match #(.NUM_PHASES(NUM_PHASES)) u_match (
        .en_i   (stop_en_i),
        .sel_i  (stop_sel_i),
        .cand_i (cand),
        .hit_o  (hit)
    );

    chan_clk_seq_core #(.NUM_PHASES(NUM_PHASES)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .hit_i     (hit),
        .stop_en_i (stop_en_i),
        .cand_o    (cand),
        .idx_o     (idx),
        .active_o  (active),
        .halted_o  (halted_o)
    );

    chan_clk_phase_dec #(.NUM_PHASES(NUM_PHASES)) u_dec (
        .active_i (active),
        .idx_i    (idx),
        .phase_o  (phase_o)
    );

    // Busy follows the sequencer's activity.
    always_comb busy_o = active;

    // R4
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_o) && (busy_o == (phase_o != '0)));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (phase_o == '0 && !busy_o && !halted_o));

endmodule

// File: tb/chan_step_clock_tb.sv
// Bench: sweeps every stop phase, stop enable, start source and release
// source, comparing outputs each clock with an arithmetic model.
module chan_step_clock_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer = 1'b0;
    logic       step = 1'b0;
    logic       stop_en = 1'b0;
    logic [2:0] stop_sel = 3'd0;
    logic [7:0] phase;
    logic       busy;
    logic       halted;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    chan_step_clock dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .xfer_strobe_i (xfer),
        .step_pulse_i  (step),
        .stop_en_i     (stop_en),
        .stop_sel_i    (stop_sel),
        .phase_o       (phase),
        .busy_o        (busy),
        .halted_o      (halted)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, {22'd0, phase, busy, halted}, 32'd0);
    endtask

    // One full cycle with optional halt; see the requirement tags per check.
    task automatic run_cycle(input bit en, input logic [2:0] sel,
                             input bit by_strobe, input bit rel_strobe);
        bit halted_done = 1'b0;
        stop_en  = en;
        stop_sel = sel;
        if (by_strobe) xfer = 1'b1; else step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        for (int p = 0; p < 8; p++) begin
            bit exp_h;
            exp_h = en && (p == int'(sel)) && !halted_done;
            // R2 R3 R4 R7 R10: phase, busy and halt flag per clock
            chk(by_strobe ? "R2/R4 phase" : "R3/R4 phase", {24'd0, phase}, 32'(1 << p));
            chk("R4 busy", {31'd0, busy}, 32'd1);
            chk(en ? "R7 halt" : "R10 halt", {31'd0, halted}, {31'd0, exp_h});
            if (exp_h) begin
                halted_done = 1'b1;
                stop_sel = sel + 3'd1;
                for (int k = 0; k < 2; k++) begin
                    @(negedge clk);
                    chk("R7 hold", {23'd0, halted, phase}, {23'd1, 8'(1 << p)});
                end
                if (rel_strobe) begin
                    xfer = 1'b0;
                    @(negedge clk);
                    chk("R8 fall", {23'd0, halted, phase}, {23'd1, 8'(1 << p)});
                    xfer = 1'b1;
                    @(negedge clk);
                end else begin
                    step = 1'b1;
                    @(negedge clk);
                    step = 1'b0;
                end
                if (p < 7) chk("R9 rehalt", {31'd0, halted}, 32'd0);
            end else begin
                if (p == 3) step = 1'b1;   // R5 ignored request
                @(negedge clk);
                step = 1'b0;
            end
        end
        chk_idle("R4/R5 end");
        @(negedge clk);
        chk_idle("R6 no retrigger");
        xfer = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        xfer = 1'b1;                 // strobe high across reset release
        repeat (3) @(negedge clk);
        chk_idle("R1 reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_idle("R1 no start");
        xfer = 1'b0;
        @(negedge clk);

        for (int en = 0; en < 2; en++)
            for (int s = 0; s < 8; s++)
                for (int src = 0; src < 2; src++)
                    for (int rel = 0; rel < 2; rel++)
                        run_cycle(en[0], s[2:0], src[0], rel[0]);

        // R1: reset while halted clears everything
        stop_en = 1'b1; stop_sel = 3'd4; step = 1'b1;
        @(negedge clk); step = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 pre", {31'd0, halted}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R1 mid reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule